// File: doc/BRIEF.md
# Word-Striped Lane Distributor

This block takes a host-side stream of fixed-width words and spreads it across a set of parallel serial lanes. Each lane receives a complete host word, never a fragment, and the lane that gets each new word is picked in strict rotation. The lane count is set at build time as the aggregate data rate divided by the rate of one lane. For example, 10000 Mb/s over 2500 Mb/s lanes gives four lanes.

One word leaves the block on every clock. When the host has nothing to send, the block fills the lanes with idle words made entirely of comma characters. A clock-tolerance stage further down the line may drop or repeat these idle words one at a time. Every packet is closed by a terminate word, which holds the end delimiter followed by pad characters. A fixed gap sequence follows it, and that gap lasts five words per lane in total. The host is held off with a ready signal for as long as the gap sequence runs.

Each lane output carries a per-byte control mask. Comma, delimiter and pad bytes are flagged as control, and payload bytes are flagged as data. Line coding, serialization, receive-side deskew and the elastic buffer are handled by other blocks.

Top module: `word_stripe_dist`

## Requirements
- R1: While reset is held, `in_ready` is 1, `lane_upd` is all zeros, and every lane word and control mask is zero.
- R2: From the first clock after reset, exactly one bit of `lane_upd` is set on every cycle. The updated lane advances 0, 1, …, LANES-1, 0 without a break, whatever kind of word is emitted.
- R3: A word accepted (`in_valid` and `in_ready` both 1) that is not a short last word appears unchanged on the next updated lane, with a control mask of zero.
- R4: With `in_ready` at 1 and `in_valid` at 0, the emitted word has the comma value 0xBC in every byte and a control mask of all ones.
- R5: An accepted last word with `in_nbytes` = k < WORD_BYTES is emitted as follows. Bytes 0..k-1 carry the payload, byte k carries the delimiter 0xFD, and the higher bytes carry pad 0xF7. Only bytes k and above are flagged as control. Byte 0 is the least significant byte.
- R6: An accepted last word with `in_nbytes` = WORD_BYTES is emitted as a plain data word. The next emitted word has 0xFD in byte 0, 0xF7 in every other byte, and a control mask of all ones.
- R7: The terminate word is followed by LANES-1 pad words (every byte 0xF7) and then 4·LANES comma idle words, all with control masks of all ones. The gap therefore spans 5·LANES words, counting the terminate word.
- R8: `in_ready` is 0 from the cycle after a last word is accepted until the final word of the gap sequence has been emitted. While `in_ready` is 0, `in_valid` has no effect, and no payload reaches any lane.
- R9: The first payload word after a gap goes to the lane that follows the lane of the last gap word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Host word present |
| in_data | input | 8·WORD_BYTES | Host word, byte 0 in the low bits |
| in_last | input | 1 | Host word ends its packet |
| in_nbytes | input | clog2(WORD_BYTES+1) | Valid bytes in a last word, 1..WORD_BYTES |
| in_ready | output | 1 | Block accepts a host word this cycle |
| lane_data | output | LANES·8·WORD_BYTES | Current word of every lane, lane 0 in the low bits |
| lane_ctrl | output | LANES·WORD_BYTES | Per-byte control flags of every lane |
| lane_upd | output | LANES | One-hot marker of the lane written on the last clock |

## Verification
The checker assumes that the host keeps `in_nbytes` within 1..WORD_BYTES whenever `in_last` is 1. It also assumes that the host changes its word only after a handshake, since the payload check compares against the word sampled in the accepting cycle. The bench follows both assumptions. It draws `in_nbytes` only from 1..WORD_BYTES, and it holds `in_valid`, `in_data`, `in_last` and `in_nbytes` steady until the word is accepted. As a result, words presented during a gap stay pending rather than being dropped or replaced. Random packet lengths and idle spacing exercise the full-word and short-word endings in every lane position.

// File: rtl/wsd_pkg.sv
`timescale 1ns/1ps
// Shared character codes and word kinds for the word-striped lane distributor.
package wsd_pkg;
    localparam logic [7:0] CH_COMMA = 8'hBC;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CH_PAD   = 8'hF7;

    typedef enum logic [1:0] {
        WK_DATA = 2'd0,
        WK_IDLE = 2'd1,
        WK_PAD  = 2'd2,
        WK_TERM = 2'd3
    } word_kind_e;
endpackage

// File: rtl/wsd_word_builder.sv
`timescale 1ns/1ps
// Builds the outgoing word and its per-byte control mask from a word kind.
// Assumes: nbytes is in 1..WORD_BYTES; a value below WORD_BYTES on a DATA
// word means the packet ends inside this word.
module wsd_word_builder
    import wsd_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int WB = 8 * WORD_BYTES,
    localparam int CW = $clog2(WORD_BYTES + 1)
) (
    input  word_kind_e            kind,
    input  logic [WB-1:0]         data,
    input  logic [CW-1:0]         nbytes,
    output logic [WB-1:0]         word,
    output logic [WORD_BYTES-1:0] ctrl
);
    // Per-byte selection of payload, delimiter, pad or comma.
    always_comb begin
        for (int b = 0; b < WORD_BYTES; b++) begin
            unique case (kind)
                WK_DATA: begin
                    if (CW'(b) < nbytes) begin
                        word[8*b +: 8] = data[8*b +: 8];
                        ctrl[b]        = 1'b0;
                    end else if (CW'(b) == nbytes) begin
                        word[8*b +: 8] = CH_TERM;
                        ctrl[b]        = 1'b1;
                    end else begin
                        word[8*b +: 8] = CH_PAD;
                        ctrl[b]        = 1'b1;
                    end
                end
                WK_TERM: begin
                    word[8*b +: 8] = (b == 0) ? CH_TERM : CH_PAD;
                    ctrl[b]        = 1'b1;
                end
                WK_PAD: begin
                    word[8*b +: 8] = CH_PAD;
                    ctrl[b]        = 1'b1;
                end
                default: begin
                    word[8*b +: 8] = CH_COMMA;
                    ctrl[b]        = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/wsd_gap_sequencer.sv
`timescale 1ns/1ps
// Decides which kind of word is emitted each cycle and runs the mandatory
// inter-packet gap: one terminate word (or a short last word carrying the
// delimiter), LANES-1 pad words, then 4*LANES deletable idle words.
// Assumes: in_nbytes is in 1..WORD_BYTES when in_last is set.
module wsd_gap_sequencer
    import wsd_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int WORD_BYTES = 4,
    localparam int CW      = $clog2(WORD_BYTES + 1),
    localparam int GAP_LEN = 5 * LANES,
    localparam int GW      = $clog2(GAP_LEN)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_last,
    input  logic [CW-1:0] in_nbytes,
    output logic        in_ready,
    output word_kind_e  kind
);
    logic          term_pend;
    logic [GW-1:0] gap_left;
    logic          take;

    // Host handshake: open only outside the gap sequence.
    always_comb begin
        in_ready = !term_pend && (gap_left == '0);
        take     = in_valid && in_ready;
    end

    // Kind of word for the current cycle.
    always_comb begin
        if (term_pend)
            kind = WK_TERM;
        else if (gap_left != '0)
            kind = (gap_left > GW'(4 * LANES)) ? WK_PAD : WK_IDLE;
        else if (take)
            kind = WK_DATA;
        else
            kind = WK_IDLE;
    end

    // Gap state: pending terminate flag and remaining gap words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_pend <= 1'b0;
            gap_left  <= '0;
        end else if (term_pend) begin
            term_pend <= 1'b0;
            gap_left  <= GW'(GAP_LEN - 1);
        end else if (gap_left != '0) begin
            gap_left  <= gap_left - 1'b1;
        end else if (take && in_last) begin
            if (in_nbytes >= CW'(WORD_BYTES))
                term_pend <= 1'b1;
            else
                gap_left  <= GW'(GAP_LEN - 1);
        end
    end
endmodule

// File: rtl/wsd_lane_rotator.sv
`timescale 1ns/1ps
// Writes one word per cycle into the lane named by a round-robin pointer and
// reports the written lane as a one-hot marker. Lane registers hold their
// last word until their turn comes again.
module wsd_lane_rotator #(
    parameter int LANES      = 4,
    parameter int WORD_BYTES = 4,
    localparam int WB = 8 * WORD_BYTES,
    localparam int RW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WB-1:0]                 word,
    input  logic [WORD_BYTES-1:0]         ctrl,
    output logic [LANES*WB-1:0]           lane_data,
    output logic [LANES*WORD_BYTES-1:0]   lane_ctrl,
    output logic [LANES-1:0]              lane_upd
);
    logic [RW-1:0] rr;

    // Round-robin pointer, wrapping after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr <= '0;
        else if (rr == RW'(LANES - 1))
            rr <= '0;
        else
            rr <= rr + 1'b1;
    end

    // Per-lane registers, loaded only when the pointer selects them.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_data[i*WB +: WB]                 <= '0;
                lane_ctrl[i*WORD_BYTES +: WORD_BYTES] <= '0;
                lane_upd[i]                           <= 1'b0;
            end else begin
                lane_upd[i] <= (rr == RW'(i));
                if (rr == RW'(i)) begin
                    lane_data[i*WB +: WB]                 <= word;
                    lane_ctrl[i*WORD_BYTES +: WORD_BYTES] <= ctrl;
                end
            end
        end
    end
endmodule

// File: rtl/word_stripe_dist.sv
`timescale 1ns/1ps
// Word-striped lane distributor: one whole host word per lane in rotation,
// with terminate, pad and comma idle words generated between packets.
// Assumes: the host holds its word stable until in_valid && in_ready, and
// in_nbytes is in 1..WORD_BYTES on a last word.
module word_stripe_dist
    import wsd_pkg::*;
#(
    parameter int AGG_MBPS   = 10000,
    parameter int LANE_MBPS  = 2500,
    parameter int WORD_BYTES = 4,
    localparam int LANES = AGG_MBPS / LANE_MBPS,
    localparam int WB    = 8 * WORD_BYTES,
    localparam int CW    = $clog2(WORD_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [WB-1:0]               in_data,
    input  logic                        in_last,
    input  logic [CW-1:0]               in_nbytes,
    output logic                        in_ready,
    output logic [LANES*WB-1:0]         lane_data,
    output logic [LANES*WORD_BYTES-1:0] lane_ctrl,
    output logic [LANES-1:0]            lane_upd
);
    word_kind_e            kind;
    logic [CW-1:0]         eff_nbytes;
    logic [WB-1:0]         word;
    logic [WORD_BYTES-1:0] ctrl;

    // Only a last word may carry fewer than a full word of payload.
    always_comb eff_nbytes = in_last ? in_nbytes : CW'(WORD_BYTES);

    wsd_gap_sequencer #(.LANES(LANES), .WORD_BYTES(WORD_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_nbytes (in_nbytes),
        .in_ready  (in_ready),
        .kind      (kind)
    );

    wsd_word_builder #(.WORD_BYTES(WORD_BYTES)) u_build (
        .kind   (kind),
        .data   (in_data),
        .nbytes (eff_nbytes),
        .word   (word),
        .ctrl   (ctrl)
    );

    wsd_lane_rotator #(.LANES(LANES), .WORD_BYTES(WORD_BYTES)) u_rot (
        .clk       (clk),
        .rst_n     (rst_n),
        .word      (word),
        .ctrl      (ctrl),
        .lane_data (lane_data),
        .lane_ctrl (lane_ctrl),
        .lane_upd  (lane_upd)
    );
endmodule

// File: rtl/word_stripe_dist_chk.sv
`timescale 1ns/1ps
// Port-level checker for word_stripe_dist; attached by bind below.
module word_stripe_dist_chk
    import wsd_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int WORD_BYTES = 4,
    localparam int WB = 8 * WORD_BYTES,
    localparam int CW = $clog2(WORD_BYTES + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [WB-1:0]               in_data,
    input logic                        in_last,
    input logic [CW-1:0]               in_nbytes,
    input logic                        in_ready,
    input logic [LANES*WB-1:0]         lane_data,
    input logic [LANES*WORD_BYTES-1:0] lane_ctrl,
    input logic [LANES-1:0]            lane_upd
);
    logic [WB-1:0]         upd_data;
    logic [WORD_BYTES-1:0] upd_ctrl;

    // Word and mask of the lane written on the last clock.
    always_comb begin
        upd_data = '0;
        upd_ctrl = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_upd[i]) begin
                upd_data = upd_data | lane_data[i*WB +: WB];
                upd_ctrl = upd_ctrl | lane_ctrl[i*WORD_BYTES +: WORD_BYTES];
            end
        end
    end

    // R2
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(lane_upd) == 1));

    // R2
    rotation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_upd != '0) |=>
            (lane_upd == {$past(lane_upd[LANES-2:0]), $past(lane_upd[LANES-1])}));

    // R3
    payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_last) |=>
            (upd_data == $past(in_data)) && (upd_ctrl == '0));

    // R4
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=>
            (upd_data == {WORD_BYTES{CH_COMMA}}) && (&upd_ctrl));

    // R8
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R7
    gap_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (&upd_ctrl));
endmodule

bind word_stripe_dist word_stripe_dist_chk #(
    .LANES(LANES),
    .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/word_stripe_dist_test.sv
`timescale 1ns/1ps
module word_stripe_dist_test;
    localparam int N   = 4;
    localparam int B   = 4;
    localparam int W   = 8 * B;
    localparam int CW  = $clog2(B + 1);
    localparam int GAP = 5 * N;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [W-1:0]      in_data;
    logic              in_last;
    logic [CW-1:0]     in_nbytes;
    logic              in_ready;
    logic [N*W-1:0]    lane_data;
    logic [N*B-1:0]    lane_ctrl;
    logic [N-1:0]      lane_upd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Bench model of the spec.
    int m_rr = 0, m_gap = 0;
    bit m_pend = 0, after_gap = 0;

    always #4 clk = ~clk;

    word_stripe_dist uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_nbytes(in_nbytes), .in_ready(in_ready),
        .lane_data(lane_data), .lane_ctrl(lane_ctrl), .lane_upd(lane_upd)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fill(input logic [7:0] c);
        return {B{c}};
    endfunction

    function automatic logic [W-1:0] short_word(input logic [W-1:0] d, input int k);
        logic [W-1:0] r;
        for (int b = 0; b < B; b++)
            r[8*b +: 8] = (b < k) ? d[8*b +: 8] : (b == k) ? 8'hFD : 8'hF7;
        return r;
    endfunction

    function automatic logic [B-1:0] short_ctrl(input int k);
        logic [B-1:0] r;
        for (int b = 0; b < B; b++) r[b] = (b >= k);
        return r;
    endfunction

    // One clock: predict, advance, compare. acc reports a handshake.
    task automatic step(output bit acc);
        logic [W-1:0] ew;
        logic [B-1:0] ec;
        int el;
        bit rdy;
        string tag, ltag;
        rdy = !m_pend && (m_gap == 0);
        chk(in_ready === rdy, "R8 ready", W'(in_ready), W'(rdy));
        acc = 0;
        el  = m_rr;
        if (m_pend) begin
            ew = {{(B-1){8'hF7}}, 8'hFD}; ec = '1; tag = "R6 terminate";
            m_pend = 0; m_gap = GAP - 1;
        end else if (m_gap > 0) begin
            if (m_gap > 4 * N) begin ew = fill(8'hF7); tag = "R7 pad"; end
            else begin ew = fill(8'hBC); tag = "R7 gap idle"; end
            ec = '1;
            m_gap--;
            if (m_gap == 0) after_gap = 1;
        end else if (in_valid) begin
            acc = 1;
            if (in_last && int'(in_nbytes) < B) begin
                ew = short_word(in_data, int'(in_nbytes));
                ec = short_ctrl(int'(in_nbytes)); tag = "R5 short last";
                m_gap = GAP - 1;
            end else begin
                ew = in_data; ec = '0; tag = "R3 data";
                if (in_last) m_pend = 1;
            end
        end else begin
            ew = fill(8'hBC); ec = '1; tag = "R4 idle";
        end
        @(posedge clk);
        @(negedge clk);
        ltag = (acc && after_gap) ? "R9 lane after gap" : "R2 lane";
        if (acc) after_gap = 0;
        chk(lane_upd === N'(1) << el, ltag, W'(lane_upd), W'(N'(1) << el));
        chk(lane_data[el*W +: W] === ew, tag, lane_data[el*W +: W], ew);
        chk(lane_ctrl[el*B +: B] === ec, {tag, " ctrl"}, W'(lane_ctrl[el*B +: B]), W'(ec));
        m_rr = (m_rr + 1) % N;
    endtask

    task automatic idle_cycles(input int n);
        bit a;
        in_valid = 0;
        for (int i = 0; i < n; i++) step(a);
    endtask

    // Sends a packet, holding each word until it is accepted (R8).
    task automatic send_pkt(input int words, input int nb);
        bit a;
        for (int i = 0; i < words; i++) begin
            in_valid  = 1;
            in_data   = $urandom;
            in_last   = (i == words - 1);
            in_nbytes = CW'(nb);
            do step(a); while (!a);
        end
        in_valid = 0;
        in_last  = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2: actual hung expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd1999));
        rst_n = 0; in_valid = 0; in_data = '0; in_last = 0; in_nbytes = CW'(B);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready === 1'b1, "R1 ready", W'(in_ready), W'(1));
        chk(lane_upd === '0, "R1 upd", W'(lane_upd), '0);
        chk(lane_data === '0, "R1 data", lane_data[W-1:0], '0);
        chk(lane_ctrl === '0, "R1 ctrl", W'(lane_ctrl), '0);
        rst_n = 1;
        idle_cycles(5);
        send_pkt(3, B);      // R6 full last word
        idle_cycles(2);
        send_pkt(1, 1);      // R5 single payload byte
        send_pkt(2, B - 1);  // R8 offered during gap, held
        send_pkt(5, B);      // R9 back to back after gap
        idle_cycles(GAP + 3);
        for (int p = 0; p < 250; p++) begin
            idle_cycles($urandom_range(0, 3));
            send_pkt($urandom_range(1, 6), $urandom_range(1, B));
        end
        idle_cycles(GAP + 2);
        summary();
    end
endmodule